// File: doc/BRIEF.md
# Restart and Return Stack Sequencer

This block carries out the stack side of two single-byte control-transfer instructions of a small 8-bit-bus processor. A restart saves the program counter to the stack one byte per transfer, lowers the stack pointer, and loads the program counter with a fixed vector. That vector is eight times a 3-bit field taken from the opcode. A return from a non-maskable interrupt reads the program counter back from the stack one byte per transfer, raises the stack pointer, and copies the saved interrupt-enable flag into the live one.

The surrounding core latches the current program counter, stack pointer and both interrupt-enable flags into the block with a one-cycle start command. The block then runs its transfers over a byte-wide request/acknowledge memory port and pulses done when the new values are ready on its outputs. A mode input picks how the program counter is handled:

- **Native mode:** 16-bit program counter, and stack addresses wrap at 64 Ki.
- **Extended mode:** 32-bit program counter. The upper word also goes through the stack, and the stack pointer is a full 32-bit quantity.

Top module: `stack_restart_seq`

## Requirements
- R1: On a restart, the new program counter bits 7-0 equal the 3-bit field `vec_sel` times 8 (so 00h, 08h, ... 38h), and bits 15-8 are zero.
- R2: A native restart writes PC[15:8] at address SP-1 first, then PC[7:0] at SP-2. It leaves `sp_out` = SP-2 and keeps PC[31:16], `iff1_out` and `iff2_out` as they were given.
- R3: An extended restart writes four bytes, in this order: PC[31:24] at SP-1, PC[23:16] at SP-2, PC[15:8] at SP-3, PC[7:0] at SP-4. It leaves `sp_out` = SP-4 with no 16-bit wrap, and clears PC[31:16] to zero.
- R4: In native mode, every stack address and the new SP low half are computed modulo 65536. `mem_addr[31:16]` is zero, and `sp_out[31:16]` keeps the value of `sp_in[31:16]`.
- R5: A native return reads PC[7:0] from SP and PC[15:8] from SP+1. It leaves `sp_out` = SP+2, keeps PC[31:16], sets `iff1_out` to the value of `iff2_in`, and leaves `iff2_out` equal to `iff2_in`.
- R6: An extended return first reads the low word (SP, SP+1), then the upper word: PC[23:16] from SP+2 and PC[31:24] from SP+3. It leaves `sp_out` = SP+4 with no 16-bit wrap.
- R7: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values into the next cycle. `mem_we` is 1 for restart writes and 0 for return reads.
- R8: `busy` rises in the cycle after an accepted start and falls in the cycle after the last acknowledged transfer. In that same cycle `done` is high for exactly one cycle.
- R9: A synchronous reset, even in the middle of a sequence, returns the block to idle: `busy`, `done` and `mem_req` are low and all result outputs are zero.
- R10: A start while `busy` is high is ignored: no extra transfer is made and the results are those of the running sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle command, accepted only when idle |
| do_return | input | 1 | 0 = restart, 1 = return from non-maskable interrupt |
| ext_mode | input | 1 | 0 = native 16-bit, 1 = extended 32-bit |
| vec_sel | input | 3 | Restart vector field from the opcode |
| pc_in | input | 32 | Program counter at start |
| sp_in | input | 32 | Stack pointer at start |
| iff1_in | input | 1 | Live interrupt-enable flag at start |
| iff2_in | input | 1 | Saved interrupt-enable flag at start |
| mem_req | output | 1 | Byte transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Transfer accepted in this cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 32 | Resulting program counter |
| sp_out | output | 32 | Resulting stack pointer |
| iff1_out | output | 1 | Resulting live interrupt-enable flag |
| iff2_out | output | 1 | Resulting saved interrupt-enable flag |

## Verification
The bench builds the block with its default parameters: a 32-bit stack pointer and program counter, a 16-bit native word, byte lanes of 8 bits, and a 3-bit vector field scaled by 8. Those values bring the 64 Ki wrap within reach with small stack pointers near 0000h and FFFFh. They also bring within reach the crossing from 0000FFFFh into 00010000h, which an extended return must not wrap. Acknowledge delays of zero to three cycles exercise the hold rule on the memory port and the exact placement of busy and done.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_MOVE = 2'd1,
      SQ_FIN  = 2'd2
   } sq_state_e;
endpackage

// File: rtl/rsq_vector.sv
module rsq_vector #(
   parameter int FIELD_W = 3,
   parameter int STEP    = 8,
   parameter int OUT_W   = 8
) (
   input  logic [FIELD_W-1:0] field,
   output logic [OUT_W-1:0]   vector
);
   localparam int SHIFT = $clog2(STEP);

   if ((1 << SHIFT) == STEP) begin : g_shift
      if ((FIELD_W + SHIFT) > OUT_W) begin : g_bad_width
         $error("rsq_vector: scaled field does not fit the output byte");
      end
      assign vector = OUT_W'(field) << SHIFT;
   end else begin : g_mult
      assign vector = OUT_W'(OUT_W'(field) * OUT_W'(STEP));
   end
endmodule

// File: rtl/rsq_addr_gen.sv
module rsq_addr_gen #(
   parameter int SP_W  = 32,
   parameter int NAT_W = 16,
   parameter int CNT_W = 3
) (
   input  logic [SP_W-1:0]  sp,
   input  logic [CNT_W-1:0] idx,
   input  logic             is_ret,
   input  logic             ext,
   output logic [SP_W-1:0]  addr
);
   logic [SP_W-1:0] full;

   if (SP_W <= NAT_W) begin : g_bad
      $error("rsq_addr_gen: stack pointer must be wider than the native word");
   end

   always_comb begin
      if (is_ret) full = sp + SP_W'(idx);
      else        full = sp - SP_W'(idx) - SP_W'(1);
   end

   always_comb begin
      if (ext) addr = full;
      else     addr = {{(SP_W-NAT_W){1'b0}}, full[NAT_W-1:0]};
   end
endmodule

// File: rtl/rsq_sp_next.sv
module rsq_sp_next #(
   parameter int SP_W  = 32,
   parameter int NAT_W = 16,
   parameter int CNT_W = 3
) (
   input  logic [SP_W-1:0]  sp,
   input  logic [CNT_W-1:0] nbytes,
   input  logic             is_ret,
   input  logic             ext,
   output logic [SP_W-1:0]  sp_new
);
   logic [SP_W-1:0] full;

   always_comb begin
      if (is_ret) full = sp + SP_W'(nbytes);
      else        full = sp - SP_W'(nbytes);
   end

   always_comb begin
      if (ext) sp_new = full;
      else     sp_new = {sp[SP_W-1:NAT_W], full[NAT_W-1:0]};
   end
endmodule

// File: rtl/rsq_byte_lane.sv
module rsq_byte_lane #(
   parameter int PC_W   = 32,
   parameter int BYTE_W = 8,
   parameter int CNT_W  = 3
) (
   input  logic [PC_W-1:0]   pc,
   input  logic [CNT_W-1:0]  lane,
   input  logic [BYTE_W-1:0] rbyte,
   output logic [BYTE_W-1:0] wbyte,
   output logic [PC_W-1:0]   pc_merged
);
   localparam int LANES = PC_W / BYTE_W;

   if ((PC_W % BYTE_W) != 0) begin : g_bad
      $error("rsq_byte_lane: program counter must be a whole number of bytes");
   end

   logic [LANES-1:0][BYTE_W-1:0] src;
   logic [LANES-1:0][BYTE_W-1:0] dst;
   logic [LANES-1:0]             hit;

   assign src = pc;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign hit[i] = (lane == CNT_W'(i));
      assign dst[i] = hit[i] ? rbyte : src[i];
   end

   always_comb begin
      wbyte = '0;
      for (int i = 0; i < LANES; i++) begin
         if (hit[i]) wbyte = src[i];
      end
   end

   assign pc_merged = dst;
endmodule

// File: rtl/stack_restart_seq.sv
module stack_restart_seq
   import rsq_pkg::*;
#(
   parameter int SP_W     = 32,
   parameter int PC_W     = 32,
   parameter int NAT_W    = 16,
   parameter int BYTE_W   = 8,
   parameter int FIELD_W  = 3,
   parameter int VEC_STEP = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              do_return,
   input  logic              ext_mode,
   input  logic [FIELD_W-1:0] vec_sel,
   input  logic [PC_W-1:0]   pc_in,
   input  logic [SP_W-1:0]   sp_in,
   input  logic              iff1_in,
   input  logic              iff2_in,
   output logic              mem_req,
   output logic              mem_we,
   output logic [SP_W-1:0]   mem_addr,
   output logic [BYTE_W-1:0] mem_wdata,
   input  logic [BYTE_W-1:0] mem_rdata,
   input  logic              mem_ack,
   output logic              busy,
   output logic              done,
   output logic [PC_W-1:0]   pc_out,
   output logic [SP_W-1:0]   sp_out,
   output logic              iff1_out,
   output logic              iff2_out
);
   localparam int EXT_BYTES = PC_W / BYTE_W;
   localparam int NAT_BYTES = NAT_W / BYTE_W;
   localparam int CNT_W     = $clog2(EXT_BYTES) + 1;

   if (PC_W != 2 * NAT_W) begin : g_bad_pc
      $error("stack_restart_seq: extended counter must be twice the native word");
   end
   if ((NAT_W % BYTE_W) != 0 || NAT_BYTES < 2) begin : g_bad_nat
      $error("stack_restart_seq: native word must hold at least two bytes");
   end
   if (SP_W < PC_W) begin : g_bad_sp
      $error("stack_restart_seq: stack pointer narrower than program counter");
   end

   sq_state_e           state;
   logic [CNT_W-1:0]    idx;
   logic                ret_q;
   logic                ext_q;
   logic [FIELD_W-1:0]  field_q;
   logic [PC_W-1:0]     pc_q;
   logic [SP_W-1:0]     sp_q;
   logic                iff1_q;
   logic                iff2_q;

   logic [CNT_W-1:0]    nbytes;
   logic [CNT_W-1:0]    last_idx;
   logic [CNT_W-1:0]    lane;
   logic                at_last;
   logic                xfer_ok;
   logic [BYTE_W-1:0]   vector;
   logic [BYTE_W-1:0]   wbyte;
   logic [PC_W-1:0]     pc_merged;
   logic [PC_W-1:0]     pc_vec;
   logic [SP_W-1:0]     addr_w;
   logic [SP_W-1:0]     sp_final;

   // Bytes moved: a native word or the full extended counter.
   assign nbytes   = ext_q ? CNT_W'(EXT_BYTES) : CNT_W'(NAT_BYTES);
   assign last_idx = nbytes - CNT_W'(1);
   assign at_last  = (idx == last_idx);
   assign xfer_ok  = (state == SQ_MOVE) && mem_ack;

   // Pushes go from the most significant byte down.
   // Pops go from the least significant byte up.
   assign lane = ret_q ? idx : (last_idx - idx);

   rsq_vector #(
      .FIELD_W (FIELD_W),
      .STEP    (VEC_STEP),
      .OUT_W   (BYTE_W)
   ) u_vector (
      .field  (field_q),
      .vector (vector)
   );

   rsq_addr_gen #(
      .SP_W  (SP_W),
      .NAT_W (NAT_W),
      .CNT_W (CNT_W)
   ) u_addr (
      .sp     (sp_q),
      .idx    (idx),
      .is_ret (ret_q),
      .ext    (ext_q),
      .addr   (addr_w)
   );

   rsq_sp_next #(
      .SP_W  (SP_W),
      .NAT_W (NAT_W),
      .CNT_W (CNT_W)
   ) u_spn (
      .sp     (sp_q),
      .nbytes (nbytes),
      .is_ret (ret_q),
      .ext    (ext_q),
      .sp_new (sp_final)
   );

   rsq_byte_lane #(
      .PC_W   (PC_W),
      .BYTE_W (BYTE_W),
      .CNT_W  (CNT_W)
   ) u_lane (
      .pc        (pc_q),
      .lane      (lane),
      .rbyte     (mem_rdata),
      .wbyte     (wbyte),
      .pc_merged (pc_merged)
   );

   // New counter after a restart.
   // The upper word is cleared in extended mode and kept in native mode.
   always_comb begin
      pc_vec = pc_q;
      pc_vec[NAT_W-1:0] = {{(NAT_W-BYTE_W){1'b0}}, vector};
      if (ext_q) pc_vec[PC_W-1:NAT_W] = '0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= SQ_IDLE;
         idx     <= '0;
         ret_q   <= 1'b0;
         ext_q   <= 1'b0;
         field_q <= '0;
         pc_q    <= '0;
         sp_q    <= '0;
         iff1_q  <= 1'b0;
         iff2_q  <= 1'b0;
      end else begin
         case (state)
            SQ_IDLE: begin
               if (start) begin
                  state   <= SQ_MOVE;
                  idx     <= '0;
                  ret_q   <= do_return;
                  ext_q   <= ext_mode;
                  field_q <= vec_sel;
                  pc_q    <= pc_in;
                  sp_q    <= sp_in;
                  iff1_q  <= iff1_in;
                  iff2_q  <= iff2_in;
               end
            end
            SQ_MOVE: begin
               if (mem_ack) begin
                  if (ret_q) pc_q <= pc_merged;
                  if (at_last) begin
                     state <= SQ_FIN;
                     sp_q  <= sp_final;
                     if (ret_q) iff1_q <= iff2_q;
                     else       pc_q   <= pc_vec;
                  end else begin
                     idx <= idx + CNT_W'(1);
                  end
               end
            end
            SQ_FIN:  state <= SQ_IDLE;
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign mem_req   = (state == SQ_MOVE);
   assign mem_we    = mem_req && !ret_q;
   assign mem_addr  = mem_req ? addr_w : '0;
   assign mem_wdata = mem_we ? wbyte : '0;
   assign busy      = (state == SQ_MOVE);
   assign done      = (state == SQ_FIN);
   assign pc_out    = pc_q;
   assign sp_out    = sp_q;
   assign iff1_out  = iff1_q;
   assign iff2_out  = iff2_q;

   // R7: a pending request holds still until it is acknowledged
   assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                 $stable(mem_wdata) && $stable(mem_we)));

   // R8: done lasts one cycle and never overlaps busy
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy);
   assert_start_busy_R8: assert property (@(posedge clk) disable iff (rst)
      (!busy && !done && start) |=> busy);
   assert_last_done_R8: assert property (@(posedge clk) disable iff (rst)
      (xfer_ok && at_last) |=> (done && !mem_req));

   // R4: native transfers stay inside the low 64 Ki
   assert_native_addr_R4: assert property (@(posedge clk) disable iff (rst)
      (mem_req && !ext_q) |-> (mem_addr[SP_W-1:NAT_W] == '0));

   // R5: the return moves the saved flag into the live one
   assert_iff_copy_R5: assert property (@(posedge clk) disable iff (rst)
      (xfer_ok && at_last && ret_q) |=> (iff1_out == $past(iff2_out) &&
                                         $stable(iff2_out)));

   // R3: an extended restart clears the counter's upper word
   assert_upper_clear_R3: assert property (@(posedge clk) disable iff (rst)
      (xfer_ok && at_last && !ret_q && ext_q) |=> (pc_out[PC_W-1:NAT_W] == '0));

   // R9: reset leaves the block idle
   assert_reset_idle_R9: assert property (@(posedge clk)
      rst |=> (!busy && !done && !mem_req));
endmodule

// File: tb/stack_restart_seq_bench.sv
`timescale 1ns/1ps
module stack_restart_seq_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic        do_return = 1'b0;
   logic        ext_mode = 1'b0;
   logic [2:0]  vec_sel = '0;
   logic [31:0] pc_in = '0;
   logic [31:0] sp_in = '0;
   logic        iff1_in = 1'b0;
   logic        iff2_in = 1'b0;
   logic        mem_req, mem_we, mem_ack;
   logic [31:0] mem_addr;
   logic [7:0]  mem_wdata, mem_rdata;
   logic        busy, done, iff1_out, iff2_out;
   logic [31:0] pc_out, sp_out;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int lat    = 0;
   int wcnt   = 0;
   bit wd_hit = 0;

   logic [7:0]  mem [logic [31:0]];
   logic [31:0] wa [0:15];
   logic [7:0]  wd [0:15];
   logic [31:0] ra [0:15];
   int wn = 0;
   int rn = 0;

   always #2 clk = ~clk;

   stack_restart_seq u_stack_restart_seq (
      .clk(clk), .rst(rst), .start(start), .do_return(do_return),
      .ext_mode(ext_mode), .vec_sel(vec_sel), .pc_in(pc_in), .sp_in(sp_in),
      .iff1_in(iff1_in), .iff2_in(iff2_in), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_ack(mem_ack), .busy(busy), .done(done), .pc_out(pc_out),
      .sp_out(sp_out), .iff1_out(iff1_out), .iff2_out(iff2_out));

   // Memory model: acknowledge after `lat` wait cycles, data driven at negedge.
   initial begin
      mem_ack   = 1'b0;
      mem_rdata = 8'h00;
   end
   always @(negedge clk) begin
      if (mem_req && !rst) begin
         if (wcnt >= lat) begin mem_ack = 1'b1; wcnt = 0; end
         else begin mem_ack = 1'b0; wcnt = wcnt + 1; end
         mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 8'hEE;
      end else begin
         mem_ack = 1'b0;
         wcnt = 0;
      end
   end
   always @(posedge clk) begin
      cyc = cyc + 1;
      if (mem_req && mem_ack) begin
         if (mem_we) begin
            if (wn < 16) begin wa[wn] = mem_addr; wd[wn] = mem_wdata; end
            mem[mem_addr] = mem_wdata;
            wn = wn + 1;
         end else begin
            if (rn < 16) ra[rn] = mem_addr;
            rn = rn + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      checks = checks + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      if (cyc > 150000 && !wd_hit) begin
         wd_hit = 1;
         chk(0, "watchdog expired", 64'(cyc), 64'd150000);
         finish_run();
      end
   end

   // Launch one sequence and wait for done. busy must stay high until then.
   task automatic run_op(input bit ret, input bit ext, input logic [2:0] fld,
                         input logic [31:0] pc, input logic [31:0] sp,
                         input bit f1, input bit f2, input int l, input string tag);
      int n = 0;
      bit busy_ok = 1;
      lat = l;
      wn = 0; rn = 0;
      @(negedge clk);
      do_return = ret; ext_mode = ext; vec_sel = fld; pc_in = pc; sp_in = sp;
      iff1_in = f1; iff2_in = f2; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1, {tag, " R8 busy after start"}, 64'(busy), 64'd1);
      while (done !== 1'b1 && n < 200) begin
         if (busy !== 1'b1) busy_ok = 0;
         @(negedge clk);
         n = n + 1;
      end
      chk(done === 1'b1 && busy === 1'b0 && busy_ok,
          {tag, " R8 done with busy low"}, {62'd0, done, busy}, 64'd2);
   endtask

   task automatic check_done_drops(input string tag);
      @(negedge clk);
      chk(done === 1'b0, {tag, " R8 done one cycle"}, 64'(done), 64'd0);
   endtask

   task automatic t_reset();
      chk(busy === 0 && done === 0 && mem_req === 0 && pc_out === 0 &&
          sp_out === 0 && iff1_out === 0,
          "R9 reset state", {busy, done, mem_req, pc_out}, 64'd0);
   endtask

   task automatic t_restart_native();
      for (int f = 0; f < 8; f += 3) begin
         run_op(0, 0, 3'(f), 32'h7777_A5C3, 32'h1234_4000, 1, 0, f % 3, "rst_nat");
         chk(pc_out === {16'h7777, 8'h00, 8'(f * 8)}, "R1 R2 vector and upper kept",
             pc_out, {16'h7777, 8'h00, 8'(f * 8)});
         chk(wn == 2 && wa[0] === 32'h0000_3FFF && wd[0] === 8'hA5 &&
             wa[1] === 32'h0000_3FFE && wd[1] === 8'hC3, "R2 write order",
             {wa[0][15:0], wd[0], wa[1][15:0], wd[1]}, 64'h3FFF_A5_3FFE_C3);
         chk(sp_out === 32'h1234_3FFE && iff1_out === 1 && iff2_out === 0,
             "R2 sp and flags", sp_out, 32'h1234_3FFE);
         check_done_drops("rst_nat");
      end
   endtask

   task automatic t_restart_ext();
      run_op(0, 1, 3'd7, 32'h89AB_CDEF, 32'h0001_0002, 0, 1, 2, "rst_ext");
      chk(pc_out === 32'h0000_0038, "R1 R3 vector and upper cleared", pc_out, 32'h38);
      chk(wn == 4 && wa[0] === 32'h0001_0001 && wd[0] === 8'h89 &&
          wa[1] === 32'h0001_0000 && wd[1] === 8'hAB &&
          wa[2] === 32'h0000_FFFF && wd[2] === 8'hCD &&
          wa[3] === 32'h0000_FFFE && wd[3] === 8'hEF, "R3 four writes in order",
          {wd[0], wd[1], wd[2], wd[3], wa[3]}, 64'h89ABCDEF_0000FFFE);
      chk(sp_out === 32'h0000_FFFE && iff1_out === 0 && iff2_out === 1,
          "R3 sp minus four", sp_out, 32'h0000_FFFE);
   endtask

   task automatic t_native_wrap();
      run_op(0, 0, 3'd2, 32'h0000_BEEF, 32'hABCD_0001, 0, 0, 0, "wrap");
      chk(wa[0] === 32'h0000_0000 && wa[1] === 32'h0000_FFFF, "R4 push wraps",
          {wa[0], wa[1]}, 64'h0000_0000_0000_FFFF);
      chk(sp_out === 32'hABCD_FFFF && pc_out === 32'h0000_0010, "R4 sp wraps",
          sp_out, 32'hABCD_FFFF);
      mem[32'h0000_FFFF] = 8'h34;
      mem[32'h0000_0000] = 8'h12;
      run_op(1, 0, 3'd0, 32'h5555_0000, 32'h0042_FFFF, 1, 0, 1, "wrap_ret");
      chk(ra[0] === 32'h0000_FFFF && ra[1] === 32'h0000_0000, "R4 pop wraps",
          {ra[0], ra[1]}, 64'h0000_FFFF_0000_0000);
      chk(pc_out === 32'h5555_1234 && sp_out === 32'h0042_0001, "R4 R5 pop result",
          {pc_out, sp_out}, 64'h5555_1234_0042_0001);
   endtask

   task automatic t_return_native();
      mem[32'h0000_2000] = 8'h9A;
      mem[32'h0000_2001] = 8'h78;
      run_op(1, 0, 3'd5, 32'hCAFE_0000, 32'h0000_2000, 0, 1, 3, "ret_nat");
      chk(rn == 2 && wn == 0 && ra[0] === 32'h2000 && ra[1] === 32'h2001,
          "R5 read order", {ra[0], ra[1]}, 64'h0000_2000_0000_2001);
      chk(pc_out === 32'hCAFE_789A && sp_out === 32'h0000_2002, "R5 pc and sp",
          {pc_out, sp_out}, 64'hCAFE_789A_0000_2002);
      chk(iff1_out === 1 && iff2_out === 1, "R5 iff2 to iff1",
          {iff1_out, iff2_out}, 2'b11);
      run_op(1, 0, 3'd0, 32'h0, 32'h0000_2000, 1, 0, 0, "ret_nat2");
      chk(iff1_out === 0 && iff2_out === 0, "R5 iff clear copied",
          {iff1_out, iff2_out}, 2'b00);
   endtask

   task automatic t_return_ext();
      mem[32'h0000_FFFE] = 8'h01;
      mem[32'h0000_FFFF] = 8'h23;
      mem[32'h0001_0000] = 8'h45;
      mem[32'h0001_0001] = 8'h67;
      run_op(1, 1, 3'd0, 32'h0, 32'h0000_FFFE, 0, 1, 1, "ret_ext");
      chk(rn == 4 && ra[2] === 32'h0001_0000 && ra[3] === 32'h0001_0001,
          "R6 upper word after low word", {ra[2], ra[3]}, 64'h0001_0000_0001_0001);
      chk(pc_out === 32'h6745_2301 && sp_out === 32'h0001_0002, "R6 pc and sp",
          {pc_out, sp_out}, 64'h6745_2301_0001_0002);
   endtask

   task automatic t_ignored_start();
      mem[32'h0000_3000] = 8'h11;
      mem[32'h0000_3001] = 8'h22;
      lat = 2; wn = 0; rn = 0;
      @(negedge clk);
      do_return = 1; ext_mode = 0; pc_in = 0; sp_in = 32'h3000; iff1_in = 0;
      iff2_in = 0; start = 1;
      @(negedge clk);
      do_return = 0; ext_mode = 1; sp_in = 32'h9000; pc_in = 32'hFFFF_FFFF;
      @(negedge clk);
      start = 0;
      while (done !== 1'b1 && cyc < 149000) @(negedge clk);
      chk(rn == 2 && wn == 0, "R10 no extra transfer", 64'(rn * 16 + wn), 64'd32);
      chk(pc_out === 32'h0000_2211 && sp_out === 32'h0000_3002,
          "R10 result of first op", {pc_out, sp_out}, 64'h0000_2211_0000_3002);
      repeat (4) @(negedge clk);
      chk(busy === 0 && mem_req === 0, "R10 stays idle", {busy, mem_req}, 64'd0);
   endtask

   task automatic t_mid_reset();
      bit held = 1;
      logic [31:0] a0;
      lat = 3;
      @(negedge clk);
      do_return = 0; ext_mode = 1; vec_sel = 3'd4; pc_in = 32'h1111_2222;
      sp_in = 32'h0000_8000; start = 1;
      @(negedge clk);
      start = 0;
      a0 = mem_addr;
      repeat (2) begin
         @(negedge clk);
         if (mem_addr !== a0 || mem_req !== 1) held = 0;
      end
      chk(held, "R7 request held while waiting", {32'(mem_req), mem_addr},
          {32'd1, a0});
      rst = 1;
      @(negedge clk);
      rst = 0;
      chk(busy === 0 && done === 0 && mem_req === 0 && pc_out === 0 &&
          sp_out === 0, "R9 mid-sequence reset", {busy, done, mem_req, pc_out},
          64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      t_reset();
      t_restart_native();
      t_restart_ext();
      t_native_wrap();
      t_return_native();
      t_return_ext();
      t_ignored_start();
      t_mid_reset();
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule